// File: doc/BRIEF.md
# Short Packet Capture Queue

This block sits behind a camera serial receiver's packet decoder and keeps the short packet headers it is handed until software collects them. Each accepted header is a 16-bit payload, a 2-bit virtual channel and a 6-bit data type. The decoder has already checked these fields. The block stores them in a 31-deep queue. Software drains the queue one entry at a time through a single read register, and each read of that register removes the entry it returns.

The block drives a small status nibble and two interrupt flags toward the interrupt controller. The first flag means "entries waiting". The second means "a header was lost". The not-empty flag sets again by itself while entries remain. Because of this, a drain loop that pops an entry and then clears the flag can stop once the flag stays clear. A synchronous flush input, tied to the subsystem's soft reset, empties the queue at once.

Top module: `spkt_capture_fifo`

## Requirements
- R1: The queue holds exactly 31 entries. `stat_o[3]` reads 1 once 31 entries are stored and reads 0 below that.
- R2: The returned word is packed as follows: payload in bits 23:8, virtual channel in bits 7:6, data type in bits 5:0. Bits 31:24 are always zero.
- R3: A pop strobe (`pop_rd_i`) removes the oldest entry. `rd_data_o` presents that entry from the clock edge that samples the strobe, so entries leave in arrival order.
- R4: `stat_o[2]` is 1 whenever at least one entry is stored. `stat_o[1:0]` are always 0.
- R5: `ne_irq_o` sets one cycle after the queue becomes non-empty and then stays set. A clear on `ne_clr_i` takes effect only if the queue is empty when the clear is sampled. Otherwise the flag stays set.
- R6: A write that arrives while the queue is full, with no pop in the same cycle, is dropped. The drop produces a one-cycle pulse on `ovf_evt_o` in the following cycle. It also sets `ovf_irq_o`, which holds until `ovf_clr_i` is sampled.
- R7: A dropped write leaves the stored entries and their order unchanged.
- R8: A pop while the queue is empty returns zero and moves no pointer. The next written entry is the next one read.
- R9: A write and a pop in the same cycle while the queue is full are both accepted. The queue stays full and no overflow is raised.
- R10: `flush_i` empties the queue in one cycle and clears both interrupt flags. It takes priority over a write or pop in the same cycle, raises no overflow, and makes a pop in that cycle return zero.
- R11: After reset, `stat_o`, `ne_irq_o`, `ovf_irq_o`, `ovf_evt_o` and `rd_data_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous queue flush (soft reset) |
| wr_i | input | 1 | Header write strobe |
| wr_data_i | input | 16 | Header payload |
| wr_vc_i | input | 2 | Virtual channel |
| wr_dt_i | input | 6 | Data type |
| pop_rd_i | input | 1 | Read strobe of the capture register; pops one entry |
| rd_data_o | output | 32 | Packed word returned by the last pop |
| stat_o | output | 4 | Status: bit 3 full, bit 2 not empty, bits 1:0 zero |
| ne_irq_o | output | 1 | Sticky, self-resetting not-empty interrupt flag |
| ne_clr_i | input | 1 | Clear request for ne_irq_o |
| ovf_irq_o | output | 1 | Sticky overflow interrupt flag |
| ovf_clr_i | input | 1 | Clear request for ovf_irq_o |
| ovf_evt_o | output | 1 | One-cycle pulse per dropped write |

## Verification
The field packing is checked with a table of headers whose payload, channel and type values are all-ones, all-zeros, alternating and walking patterns. A swapped, shifted or truncated field shows up as a mismatch in a specific bit range. The queue is filled to 31, which separates a true 31-deep store from a power-of-two one. Full-cycle sequences are then run: a dropped write, a write and pop together while full, and a drain that crosses the pointer wrap. These separate wrong acceptance from wrong ordering. Pops on an empty queue, clears while entries remain, and a flush that coincides with a write and a pop on a full queue cover the sticky-flag and priority rules.

// File: rtl/spkt_pkg.sv
package spkt_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned VC_W   = 2;
  localparam int unsigned DT_W   = 6;
  localparam int unsigned ENT_W  = DATA_W + VC_W + DT_W;
  localparam int unsigned WORD_W = 32;

  typedef logic [ENT_W-1:0] entry_t;

  function automatic entry_t pack_entry(logic [DATA_W-1:0] d, logic [VC_W-1:0] vc,
                                        logic [DT_W-1:0] dt);
    return {d, vc, dt};
  endfunction

  function automatic logic [WORD_W-1:0] to_word(entry_t e);
    return {{(WORD_W-ENT_W){1'b0}}, e};
  endfunction
endpackage

// File: rtl/spkt_store.sv
module spkt_store
  import spkt_pkg::*;
#(
  parameter int unsigned DEPTH = 31
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   flush_i,
  input  logic   push_i,
  input  entry_t push_ent_i,
  input  logic   pop_i,
  output entry_t head_o,
  output logic   pop_ok_o,
  output logic   drop_o,
  output logic   full_o,
  output logic   not_empty_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  entry_t         mem_q [DEPTH];
  logic [PW-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]  cnt_q;
  logic           push_ok;

  assign full_o      = (cnt_q == FULLC);
  assign not_empty_o = (cnt_q != '0);
  assign pop_ok_o    = pop_i & not_empty_o & ~flush_i;
  assign push_ok     = push_i & ~flush_i & (~full_o | pop_ok_o);
  assign drop_o      = push_i & ~flush_i & full_o & ~pop_ok_o;
  assign head_o      = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= push_ent_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (pop_ok_o) rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      if (push_ok && !pop_ok_o) cnt_q <= cnt_q + 1'b1;
      else if (!push_ok && pop_ok_o) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/spkt_flags.sv
module spkt_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic ne_lvl_i,
  input  logic ne_clr_i,
  input  logic drop_i,
  input  logic ovf_clr_i,
  output logic ne_irq_o,
  output logic ovf_irq_o,
  output logic ovf_evt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ne_irq_o  <= 1'b0;
      ovf_irq_o <= 1'b0;
      ovf_evt_o <= 1'b0;
    end else if (flush_i) begin
      ne_irq_o  <= 1'b0;
      ovf_irq_o <= 1'b0;
      ovf_evt_o <= 1'b0;
    end else begin
      // level re-asserts over a clear while entries remain
      ne_irq_o  <= (ne_irq_o & ~ne_clr_i) | ne_lvl_i;
      ovf_irq_o <= (ovf_irq_o & ~ovf_clr_i) | drop_i;
      ovf_evt_o <= drop_i;
    end
  end
endmodule

// File: rtl/spkt_capture_fifo.sv
module spkt_capture_fifo
  import spkt_pkg::*;
#(
  parameter int unsigned DEPTH = 31
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        flush_i,
  input  logic        wr_i,
  input  logic [15:0] wr_data_i,
  input  logic [1:0]  wr_vc_i,
  input  logic [5:0]  wr_dt_i,
  input  logic        pop_rd_i,
  output logic [31:0] rd_data_o,
  output logic [3:0]  stat_o,
  output logic        ne_irq_o,
  input  logic        ne_clr_i,
  output logic        ovf_irq_o,
  input  logic        ovf_clr_i,
  output logic        ovf_evt_o
);
  entry_t head;
  logic   pop_ok, drop, full, not_empty;

  spkt_store #(.DEPTH(DEPTH)) i_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .push_i      (wr_i),
    .push_ent_i  (pack_entry(wr_data_i, wr_vc_i, wr_dt_i)),
    .pop_i       (pop_rd_i),
    .head_o      (head),
    .pop_ok_o    (pop_ok),
    .drop_o      (drop),
    .full_o      (full),
    .not_empty_o (not_empty)
  );

  spkt_flags i_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .ne_lvl_i  (not_empty),
    .ne_clr_i  (ne_clr_i),
    .drop_i    (drop),
    .ovf_clr_i (ovf_clr_i),
    .ne_irq_o  (ne_irq_o),
    .ovf_irq_o (ovf_irq_o),
    .ovf_evt_o (ovf_evt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else if (pop_rd_i) rd_data_o <= pop_ok ? to_word(head) : '0;
  end

  assign stat_o = {full, not_empty, 2'b00};
endmodule

// File: rtl/spkt_capture_fifo_chk.sv
module spkt_capture_fifo_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        flush_i,
  input logic        wr_i,
  input logic        pop_rd_i,
  input logic [31:0] rd_data_o,
  input logic [3:0]  stat_o,
  input logic        ne_irq_o,
  input logic        ovf_irq_o,
  input logic        ovf_evt_o
);
  // R2
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[31:24] == 8'h00);
  // R4
  low_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[1:0] == 2'b00 && (stat_o[3] -> stat_o[2]));
  // R4
  wr_sets_ne_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !flush_i) |=> stat_o[2]);
  // R6
  ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_o |-> $past(wr_i && stat_o[3] && !pop_rd_i && !flush_i));
  // R6
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_o |-> ovf_irq_o);
  // R8
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_rd_i && !stat_o[2]) |=> rd_data_o == 32'h0);
  // R9
  full_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && pop_rd_i && stat_o[3] && !flush_i) |=> stat_o[3] && !ovf_evt_o);
  // R10
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> stat_o == 4'h0 && !ne_irq_o && !ovf_irq_o && !ovf_evt_o);
endmodule

bind spkt_capture_fifo spkt_capture_fifo_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .flush_i   (flush_i),
  .wr_i      (wr_i),
  .pop_rd_i  (pop_rd_i),
  .rd_data_o (rd_data_o),
  .stat_o    (stat_o),
  .ne_irq_o  (ne_irq_o),
  .ovf_irq_o (ovf_irq_o),
  .ovf_evt_o (ovf_evt_o)
);

// File: tb/test_spkt_capture_fifo.sv
`timescale 1ns/1ps
module test_spkt_capture_fifo;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0, wr_i = 1'b0, pop_rd_i = 1'b0;
  logic        ne_clr_i = 1'b0, ovf_clr_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [1:0]  wr_vc_i = '0;
  logic [5:0]  wr_dt_i = '0;
  logic [31:0] rd_data_o;
  logic [3:0]  stat_o;
  logic        ne_irq_o, ovf_irq_o, ovf_evt_o;

  int total = 0;
  int bad = 0;

  always #10 clk_i = ~clk_i;

  spkt_capture_fifo i_spkt_capture_fifo (.*);

  localparam int NV = 6;
  localparam logic [15:0] T_D  [NV] = '{16'hFFFF, 16'h0000, 16'hA5A5, 16'h5A5A, 16'h0001, 16'h8000};
  localparam logic [1:0]  T_VC [NV] = '{2'd3, 2'd0, 2'd2, 2'd1, 2'd0, 2'd3};
  localparam logic [5:0]  T_DT [NV] = '{6'h3F, 6'h00, 6'h2A, 6'h15, 6'h01, 6'h20};

  function automatic logic [31:0] expw(logic [15:0] d, logic [1:0] vc, logic [5:0] dt);
    logic [31:0] w = '0;
    w[23:8] = d;
    w[7:6]  = vc;
    w[5:0]  = dt;
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic push(logic [15:0] d, logic [1:0] vc, logic [5:0] dt);
    wr_i = 1'b1; wr_data_i = d; wr_vc_i = vc; wr_dt_i = dt;
    tick();
    wr_i = 1'b0;
  endtask

  task automatic pop_chk(string req, logic [31:0] exp);
    pop_rd_i = 1'b1;
    tick();
    pop_rd_i = 1'b0;
    chk(req, rd_data_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    // R11 reset state
    chk("R11", {rd_data_o[31:0]}, 32'h0);
    chk("R11", {25'h0, stat_o, ne_irq_o, ovf_irq_o, ovf_evt_o}, 32'h0);
    rst_ni = 1'b1;
    tick();

    // table walk: R2 packing, R3 order, R4 status
    for (int i = 0; i < NV; i++) push(T_D[i], T_VC[i], T_DT[i]);
    chk("R4", {28'h0, stat_o}, 32'h4);
    chk("R5", {31'h0, ne_irq_o}, 32'h1);
    for (int i = 0; i < NV; i++) pop_chk("R2/R3", expw(T_D[i], T_VC[i], T_DT[i]));
    chk("R4", {28'h0, stat_o}, 32'h0);

    // R8 empty pop
    pop_chk("R8", 32'h0);
    chk("R8", {28'h0, stat_o}, 32'h0);
    push(16'h1234, 2'd1, 6'h12);
    pop_chk("R8", expw(16'h1234, 2'd1, 6'h12));

    // R5 sticky not-empty
    tick();
    ne_clr_i = 1'b1; tick(); ne_clr_i = 1'b0;
    chk("R5", {31'h0, ne_irq_o}, 32'h0);
    push(16'h0A0A, 2'd0, 6'h01);
    push(16'h0B0B, 2'd0, 6'h02);
    tick();
    ne_clr_i = 1'b1; tick(); ne_clr_i = 1'b0;
    chk("R5", {31'h0, ne_irq_o}, 32'h1);
    pop_chk("R5", expw(16'h0A0A, 2'd0, 6'h01));
    ne_clr_i = 1'b1; tick(); ne_clr_i = 1'b0;
    chk("R5", {31'h0, ne_irq_o}, 32'h1);
    pop_chk("R5", expw(16'h0B0B, 2'd0, 6'h02));
    ne_clr_i = 1'b1; tick(); ne_clr_i = 1'b0;
    chk("R5", {31'h0, ne_irq_o}, 32'h0);

    // R1 depth, R6 overflow, R7 drop keeps contents
    for (int i = 0; i < 30; i++) push(16'(i), 2'(i), 6'(i));
    chk("R1", {28'h0, stat_o}, 32'h4);
    push(16'd30, 2'd2, 6'd30);
    chk("R1", {28'h0, stat_o}, 32'hC);
    chk("R6", {31'h0, ovf_evt_o}, 32'h0);
    push(16'hDEAD, 2'd3, 6'h3F);
    chk("R6", {30'h0, ovf_evt_o, ovf_irq_o}, 32'h3);
    tick();
    chk("R6", {30'h0, ovf_evt_o, ovf_irq_o}, 32'h1);
    chk("R1", {28'h0, stat_o}, 32'hC);

    // R9 write and pop together while full
    wr_i = 1'b1; wr_data_i = 16'h0BEE; wr_vc_i = 2'd1; wr_dt_i = 6'h2C; pop_rd_i = 1'b1;
    tick();
    wr_i = 1'b0; pop_rd_i = 1'b0;
    chk("R9", rd_data_o, expw(16'd0, 2'd0, 6'd0));
    chk("R9", {28'h0, stat_o}, 32'hC);
    chk("R9", {31'h0, ovf_evt_o}, 32'h0);

    // R7 drain: dropped word absent, order kept across wrap
    for (int i = 1; i < 31; i++) pop_chk("R7", expw(16'(i), 2'(i), 6'(i)));
    pop_chk("R7", expw(16'h0BEE, 2'd1, 6'h2C));
    chk("R7", {28'h0, stat_o}, 32'h0);
    ovf_clr_i = 1'b1; tick(); ovf_clr_i = 1'b0;
    chk("R6", {31'h0, ovf_irq_o}, 32'h0);

    // R10 flush on full queue with write and pop in same cycle
    for (int i = 0; i < 31; i++) push(16'hC000 + 16'(i), 2'd2, 6'h05);
    push(16'hFFFF, 2'd0, 6'h00);
    chk("R10", {31'h0, ovf_irq_o}, 32'h1);
    flush_i = 1'b1; wr_i = 1'b1; pop_rd_i = 1'b1;
    tick();
    flush_i = 1'b0; wr_i = 1'b0; pop_rd_i = 1'b0;
    chk("R10", {28'h0, stat_o}, 32'h0);
    chk("R10", rd_data_o, 32'h0);
    chk("R10", {29'h0, ne_irq_o, ovf_irq_o, ovf_evt_o}, 32'h0);
    tick();
    chk("R10", {29'h0, ne_irq_o, ovf_irq_o, ovf_evt_o}, 32'h0);
    pop_chk("R10", 32'h0);
    push(16'h7777, 2'd3, 6'h11);
    pop_chk("R10", expw(16'h7777, 2'd3, 6'h11));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule